// File: doc/BRIEF.md
# PTP Slave Offset and Delay Calculator

This block sits in the timing subsystem of a time-synchronisation slave. It follows one two-step delay request-response exchange with the time master and collects four timestamps in protocol order. The local receive time of Sync (t2) comes first. The master's precise send time, carried later in Follow_Up (t1), comes second. The local send time of Delay_Req (t3) comes third. The master's receive time of that request, returned in Delay_Resp (t4), comes last. Each timestamp arrives as a one-cycle strobe together with a 64-bit unsigned nanosecond value. Message parsing and hardware timestamping happen upstream.

When the fourth timestamp has been taken, the block computes the mean path delay and the offset of the slave clock from the master, both as signed nanosecond values. It registers them and marks them with a one-cycle valid pulse. It assumes a symmetric link. On an asymmetric link the delay is the mean of the two directions, and the offset carries an error equal to how far the master-to-slave delay departs from that mean. A new Sync always starts a fresh exchange. A Follow_Up or Delay_Resp strobe that arrives at the wrong point in the exchange is dropped and sets a sticky error flag.

Top module: `ptp_offset_delay`

## Requirements
- R1: After synchronous reset, `res_valid` and `seq_err` are 0, and `offset_ns` and `delay_ns` are 0.
- R2: `delay_ns` = floor(((t2 − t1) + (t4 − t3)) / 2). The sum is formed with one guard bit, so two large positive differences do not overflow.
- R3: `offset_ns` = floor(((t2 − t1) − (t4 − t3)) / 2). Halving is an arithmetic right shift, so −3 gives −2.
- R4: Each difference is taken modulo 2^64 and read as a two's-complement signed value, so a counter that wraps between the two timestamps still gives the small true difference.
- R5: Timestamps are accepted only in the order t2, t1, t3, t4. Each is latched from its value bus in the cycle its strobe is accepted.
- R6: `res_valid` is high for exactly one cycle, two rising edges after the edge that samples the accepted Delay_Resp strobe. `offset_ns` and `delay_ns` change only at that moment and hold their values until the next completed exchange.
- R7: A Sync strobe at any point restarts the exchange with the new t2 and discards earlier partial timestamps. It does not set `seq_err`.
- R8: A Follow_Up strobe outside the wait-for-t1 step, or a Delay_Resp strobe outside the wait-for-t4 step, is ignored: it latches no value and produces no result. It sets `seq_err`, which stays 1 until reset.
- R9: A Delay_Req strobe outside the wait-for-t3 step is ignored and does not set `seq_err`.
- R10: When Sync is strobed in the same cycle as any other strobe, only Sync takes effect. The other strobes are dropped without setting `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_stb | input | 1 | Sync received; `sync_rx_ts` holds t2 |
| sync_rx_ts | input | 64 | Local receive time of Sync (t2), ns |
| fup_stb | input | 1 | Follow_Up received; `fup_origin_ts` holds t1 |
| fup_origin_ts | input | 64 | Master origin time of Sync (t1), ns |
| dreq_stb | input | 1 | Delay_Req sent; `dreq_tx_ts` holds t3 |
| dreq_tx_ts | input | 64 | Local send time of Delay_Req (t3), ns |
| dresp_stb | input | 1 | Delay_Resp received; `dresp_rx_ts` holds t4 |
| dresp_rx_ts | input | 64 | Master receive time of Delay_Req (t4), ns |
| res_valid | output | 1 | One-cycle pulse marking new results |
| offset_ns | output | 64 | Signed slave-minus-master offset, ns |
| delay_ns | output | 64 | Signed mean path delay, ns |
| seq_err | output | 1 | Sticky out-of-sequence flag |

## Verification
The hardest cases to reach are those where a stray strobe lands in the middle of an exchange and must leave no trace. Examples are a Delay_Req carrying a bogus time before Follow_Up, a Follow_Up that shares a cycle with a fresh Sync, and an early Delay_Resp. Each of these would be hidden if the exchange simply ran to completion afterwards. The stimulus therefore gives every stray strobe a timestamp that would visibly change the final offset or delay. It then completes the exchange with known-good values, so a design that wrongly accepts the stray value produces a wrong result or a spurious error flag. Arithmetic corners are covered from a vector table, including odd and negative sums, counter wrap and the guard bit.

// File: rtl/ptp_calc_pkg.sv
package ptp_calc_pkg;

    localparam int TS_W = 64;

    // Exchange step: which timestamp the sequencer is waiting for next.
    typedef enum logic [1:0] {
        PH_IDLE        = 2'd0,
        PH_WAIT_ORIGIN = 2'd1,
        PH_WAIT_DREQ   = 2'd2,
        PH_WAIT_DRESP  = 2'd3
    } phase_e;

    // One-hot capture enables produced by the sequencer.
    typedef struct packed {
        logic t2;
        logic t1;
        logic t3;
        logic t4;
    } take_t;

endpackage

// File: rtl/ptp_xchg_seq.sv
module ptp_xchg_seq
    import ptp_calc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_stb,
    input  logic  fup_stb,
    input  logic  dreq_stb,
    input  logic  dresp_stb,
    output take_t take,
    output logic  seq_err
);

    phase_e phase_q, phase_d;
    logic   bad_strobe;

    always_comb begin
        take       = '0;
        phase_d    = phase_q;
        bad_strobe = 1'b0;
        if (sync_stb) begin
            take.t2 = 1'b1;
            phase_d = PH_WAIT_ORIGIN;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    bad_strobe = fup_stb | dresp_stb;
                end
                PH_WAIT_ORIGIN: begin
                    bad_strobe = dresp_stb;
                    if (fup_stb) begin
                        take.t1 = 1'b1;
                        phase_d = PH_WAIT_DREQ;
                    end
                end
                PH_WAIT_DREQ: begin
                    bad_strobe = fup_stb | dresp_stb;
                    if (dreq_stb) begin
                        take.t3 = 1'b1;
                        phase_d = PH_WAIT_DRESP;
                    end
                end
                PH_WAIT_DRESP: begin
                    bad_strobe = fup_stb;
                    if (dresp_stb) begin
                        take.t4 = 1'b1;
                        phase_d = PH_IDLE;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            seq_err <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (bad_strobe) seq_err <= 1'b1;
        end
    end

    // R7: a Sync always puts the sequencer back to waiting for t1
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        sync_stb |=> phase_q == PH_WAIT_ORIGIN);

    // R8: once raised, the error flag stays raised
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    // R8: Follow_Up while idle is an ordering error
    assert_idle_fup_err_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && fup_stb && !sync_stb) |=> seq_err);

    // R5: at most one timestamp is captured per cycle
    assert_one_take_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take.t2, take.t1, take.t3, take.t4}));

    // R9: Delay_Req alone never raises the error flag
    assert_dreq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!seq_err && dreq_stb && !fup_stb && !dresp_stb) |=> !seq_err);

endmodule

// File: rtl/ptp_ts_store.sv
module ptp_ts_store
    import ptp_calc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  take_t        take,
    input  logic [W-1:0] t2_in,
    input  logic [W-1:0] t1_in,
    input  logic [W-1:0] t3_in,
    input  logic [W-1:0] t4_in,
    output logic [W-1:0] t1_q,
    output logic [W-1:0] t2_q,
    output logic [W-1:0] t3_q,
    output logic [W-1:0] t4_q,
    output logic         calc_go
);

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_q    <= '0;
            t2_q    <= '0;
            t3_q    <= '0;
            t4_q    <= '0;
            calc_go <= 1'b0;
        end else begin
            if (take.t2) t2_q <= t2_in;
            if (take.t1) t1_q <= t1_in;
            if (take.t3) t3_q <= t3_in;
            if (take.t4) t4_q <= t4_in;
            calc_go <= take.t4;
        end
    end

    // R5: t1 register only moves when Follow_Up was accepted
    assert_t1_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !take.t1 |=> $stable(t1_q));

endmodule

// File: rtl/ptp_offset_math.sv
module ptp_offset_math #(
    parameter int W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                calc_go,
    input  logic [W-1:0]        t1,
    input  logic [W-1:0]        t2,
    input  logic [W-1:0]        t3,
    input  logic [W-1:0]        t4,
    output logic signed [W-1:0] offset_q,
    output logic signed [W-1:0] delay_q,
    output logic                valid_q
);

    localparam int GW = W + 1;

    logic [W-1:0]         raw_ms, raw_sm;
    logic signed [GW-1:0] ms_ext, sm_ext, sum_g, dif_g, half_sum, half_dif;

    always_comb begin
        raw_ms   = t2 - t1;
        raw_sm   = t4 - t3;
        ms_ext   = $signed({raw_ms[W-1], raw_ms});
        sm_ext   = $signed({raw_sm[W-1], raw_sm});
        sum_g    = ms_ext + sm_ext;
        dif_g    = ms_ext - sm_ext;
        half_sum = sum_g >>> 1;
        half_dif = dif_g >>> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
            delay_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= calc_go;
            if (calc_go) begin
                offset_q <= half_dif[W-1:0];
                delay_q  <= half_sum[W-1:0];
            end
        end
    end

    // R6: the valid strobe is a single-cycle pulse
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R6: results hold between completions
    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> ($stable(offset_q) && $stable(delay_q)));

endmodule

// File: rtl/ptp_offset_delay.sv
module ptp_offset_delay
    import ptp_calc_pkg::*;
#(
    parameter int W = ptp_calc_pkg::TS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_stb,
    input  logic [W-1:0]        sync_rx_ts,
    input  logic                fup_stb,
    input  logic [W-1:0]        fup_origin_ts,
    input  logic                dreq_stb,
    input  logic [W-1:0]        dreq_tx_ts,
    input  logic                dresp_stb,
    input  logic [W-1:0]        dresp_rx_ts,
    output logic                res_valid,
    output logic signed [W-1:0] offset_ns,
    output logic signed [W-1:0] delay_ns,
    output logic                seq_err
);

    take_t        take;
    logic [W-1:0] t1_q, t2_q, t3_q, t4_q;
    logic         calc_go;

    ptp_xchg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .sync_stb  (sync_stb),
        .fup_stb   (fup_stb),
        .dreq_stb  (dreq_stb),
        .dresp_stb (dresp_stb),
        .take      (take),
        .seq_err   (seq_err)
    );

    ptp_ts_store #(.W(W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .t2_in   (sync_rx_ts),
        .t1_in   (fup_origin_ts),
        .t3_in   (dreq_tx_ts),
        .t4_in   (dresp_rx_ts),
        .t1_q    (t1_q),
        .t2_q    (t2_q),
        .t3_q    (t3_q),
        .t4_q    (t4_q),
        .calc_go (calc_go)
    );

    ptp_offset_math #(.W(W)) u_math (
        .clk      (clk),
        .rst      (rst),
        .calc_go  (calc_go),
        .t1       (t1_q),
        .t2       (t2_q),
        .t3       (t3_q),
        .t4       (t4_q),
        .offset_q (offset_ns),
        .delay_q  (delay_ns),
        .valid_q  (res_valid)
    );

    // R6: accepted Delay_Resp leads to valid two edges later
    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        take.t4 |-> ##2 res_valid);

endmodule

// File: tb/ptp_offset_delay_tb.sv
module ptp_offset_delay_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_stb = 0, fup_stb = 0, dreq_stb = 0, dresp_stb = 0;
    logic [63:0] sync_rx_ts = 0, fup_origin_ts = 0, dreq_tx_ts = 0, dresp_rx_ts = 0;
    logic        res_valid, seq_err;
    logic signed [63:0] offset_ns, delay_ns;

    int n_run = 0;
    int n_fail = 0;
    int vcnt = 0;

    always #10 clk = ~clk;

    ptp_offset_delay u_dut (
        .clk(clk), .rst(rst),
        .sync_stb(sync_stb), .sync_rx_ts(sync_rx_ts),
        .fup_stb(fup_stb), .fup_origin_ts(fup_origin_ts),
        .dreq_stb(dreq_stb), .dreq_tx_ts(dreq_tx_ts),
        .dresp_stb(dresp_stb), .dresp_rx_ts(dresp_rx_ts),
        .res_valid(res_valid), .offset_ns(offset_ns),
        .delay_ns(delay_ns), .seq_err(seq_err)
    );

    always @(negedge clk) if (res_valid) vcnt++;

    localparam int NV = 6;
    localparam logic [63:0] TV_T1 [NV] = '{64'd1000, 64'd5000, 64'd0, 64'd100,
                                           64'hFFFF_FFFF_FFFF_FF00, 64'd0};
    localparam logic [63:0] TV_T2 [NV] = '{64'd1600, 64'd5300, 64'd101, 64'd100,
                                           64'h100, 64'h7FFF_FFFF_FFFF_FFFF};
    localparam logic [63:0] TV_T3 [NV] = '{64'd2000, 64'd6000, 64'd200, 64'd0,
                                           64'h200, 64'd0};
    localparam logic [63:0] TV_T4 [NV] = '{64'd2400, 64'd6700, 64'd300, 64'd3,
                                           64'h300, 64'h7FFF_FFFF_FFFF_FFFF};
    localparam logic signed [63:0] TV_OFF [NV] = '{64'sd100, -64'sd200, 64'sd0,
                                                   -64'sd2, 64'sd128, 64'sd0};
    localparam logic signed [63:0] TV_DLY [NV] = '{64'sd500, 64'sd500, 64'sd100,
                                                   64'sd1, 64'sd384,
                                                   64'sh7FFF_FFFF_FFFF_FFFF};

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
        end
    endtask

    // kind: 0 Sync, 1 Follow_Up, 2 Delay_Req, 3 Delay_Resp
    task automatic pulse(input int kind, input logic [63:0] v);
        @(negedge clk);
        case (kind)
            0: begin sync_stb = 1; sync_rx_ts = v; end
            1: begin fup_stb = 1; fup_origin_ts = v; end
            2: begin dreq_stb = 1; dreq_tx_ts = v; end
            default: begin dresp_stb = 1; dresp_rx_ts = v; end
        endcase
        @(negedge clk);
        sync_stb = 0; fup_stb = 0; dreq_stb = 0; dresp_stb = 0;
    endtask

    task automatic full_xchg(input logic [63:0] a1, input logic [63:0] a2,
                             input logic [63:0] a3, input logic [63:0] a4);
        pulse(0, a2);
        pulse(1, a1);
        pulse(2, a3);
        pulse(3, a4);
    endtask

    // Called right after the Delay_Resp pulse task returns.
    task automatic expect_result(input string tag, input logic signed [63:0] eo,
                                 input logic signed [63:0] ed);
        check({tag, " valid not yet"}, {63'd0, res_valid}, 64'd0);
        @(negedge clk);
        check({tag, " R6 valid pulse"}, {63'd0, res_valid}, 64'd1);
        check({tag, " offset"}, offset_ns, eo);
        check({tag, " delay"}, delay_ns, ed);
        @(negedge clk);
        check({tag, " R6 valid drops"}, {63'd0, res_valid}, 64'd0);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int vbase;
        do_reset();
        // R1 reset state
        check("R1 valid", {63'd0, res_valid}, 64'd0);
        check("R1 err", {63'd0, seq_err}, 64'd0);
        check("R1 offset", offset_ns, 64'd0);
        check("R1 delay", delay_ns, 64'd0);

        // R2 R3 R4 vector table
        for (int i = 0; i < NV; i++) begin
            full_xchg(TV_T1[i], TV_T2[i], TV_T3[i], TV_T4[i]);
            expect_result($sformatf("R2_R3_R4 vec%0d", i), TV_OFF[i], TV_DLY[i]);
        end
        check("R8 no err after clean table", {63'd0, seq_err}, 64'd0);

        // R6 hold
        repeat (5) @(negedge clk);
        check("R6 offset hold", offset_ns, TV_OFF[NV-1]);
        check("R6 delay hold", delay_ns, TV_DLY[NV-1]);

        // R7 restart discards stale t2/t1
        pulse(0, 64'd9999);
        pulse(1, 64'd1);
        full_xchg(64'd1000, 64'd1600, 64'd2000, 64'd2400);
        expect_result("R7 restart", 64'sd100, 64'sd500);
        check("R7 no err", {63'd0, seq_err}, 64'd0);

        // R9 Delay_Req out of sequence ignored silently
        pulse(0, 64'd1600);
        pulse(2, 64'd0);
        pulse(1, 64'd1000);
        pulse(2, 64'd2000);
        pulse(3, 64'd2400);
        expect_result("R9 early dreq", 64'sd100, 64'sd500);
        check("R9 no err", {63'd0, seq_err}, 64'd0);

        // R10 Sync wins over a simultaneous Follow_Up
        @(negedge clk);
        sync_stb = 1; sync_rx_ts = 64'd1600;
        fup_stb = 1; fup_origin_ts = 64'd50;
        @(negedge clk);
        sync_stb = 0; fup_stb = 0;
        pulse(1, 64'd1000);
        pulse(2, 64'd2000);
        pulse(3, 64'd2400);
        expect_result("R10 simultaneous", 64'sd100, 64'sd500);
        check("R10 no err", {63'd0, seq_err}, 64'd0);

        // R8 early Delay_Resp ignored, error sticky
        vbase = vcnt;
        pulse(0, 64'd1600);
        pulse(3, 64'd99999);
        check("R8 err set", {63'd0, seq_err}, 64'd1);
        check("R8 no valid from stray", vcnt - vbase, 0);
        pulse(1, 64'd1000);
        pulse(2, 64'd2000);
        pulse(3, 64'd2400);
        expect_result("R8 after stray dresp", 64'sd100, 64'sd500);
        check("R8 err sticky", {63'd0, seq_err}, 64'd1);

        // R1 reset clears, R8 Follow_Up while idle
        do_reset();
        check("R1 err cleared", {63'd0, seq_err}, 64'd0);
        check("R1 offset cleared", offset_ns, 64'd0);
        vbase = vcnt;
        pulse(1, 64'd5);
        check("R8 idle fup err", {63'd0, seq_err}, 64'd1);
        repeat (3) @(negedge clk);
        check("R8 idle fup no valid", vcnt - vbase, 0);
        check("R8 idle fup offset kept", offset_ns, 64'd0);

        // R5 order: Follow_Up while waiting for t3 is not latched as t1
        do_reset();
        pulse(0, 64'd1600);
        pulse(1, 64'd1000);
        pulse(1, 64'd0);
        pulse(2, 64'd2000);
        pulse(3, 64'd2400);
        expect_result("R5 order", 64'sd100, 64'sd500);
        check("R5 late fup err", {63'd0, seq_err}, 64'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule